// File: doc/BRIEF.md
# Transmit FIFO Early-Release Controller

This block decides when space held by the frame now being sent in a transmit frame FIFO can be handed back for the next frame. It sits between a half-duplex Ethernet MAC and the FIFO space accounting. It counts the bytes of the current frame that have gone out to the wire. Once a programmable threshold is reached, it returns that whole amount in one release pulse, and from then on it returns each byte as soon as it is sent. Releasing early lets a following frame start filling the FIFO sooner.

The cost is that a frame whose head has been released can no longer be retried. If a collision arrives before the threshold, the block asks the MAC to rewind to the start of the frame and restarts its count. If a collision arrives after the threshold, the block raises a release error, records the identifier of the frame, and stops the transmitter. The transmitter stays stopped until software writes the enable bit. The all-ones threshold code turns early release off, and the frame's space is then returned only when the frame ends.

The controller is a four-state machine:
- IDLE waits for a frame start.
- HOLD counts bytes with nothing yet released.
- STREAM releases each byte as it is sent.
- HALT holds the transmitter stopped after a release error.

Transitions:
- IDLE→HOLD on frame start.
- HOLD→STREAM on threshold crossing.
- HOLD→IDLE on frame end.
- HOLD→HOLD with a rewind on collision.
- STREAM→IDLE on frame end.
- STREAM→HALT on collision.
- HALT→IDLE on the enable write.

Top module: `txrel_ctrl`

## Requirements
- R1: After reset, `tx_en` is 1, `err_flag` is 0, `err_frame_id` is 0, and `rel_valid` and `rewind` are 0. `rel_bytes` is 0 in every cycle where `rel_valid` is 0.
- R2: The byte threshold is `thresh_words` × 16. While a frame is in HOLD, nothing is released. On the cycle after the byte that brings the frame's byte count to at least the byte threshold, one pulse on `rel_valid` carries the full count in `rel_bytes`.
- R3: After the crossing, each `byte_sent` gives a `rel_valid` pulse with `rel_bytes` = 1 on the following cycle.
- R4: A `thresh_words` value of all ones (0xFF) disables early release. The frame then stays in HOLD, and on the cycle after `frame_end` its whole byte count is released in one pulse.
- R5: A frame that ends before reaching the threshold releases its whole byte count on the cycle after `frame_end`. A frame of zero bytes gives no pulse.
- R6: A `collision` in HOLD gives a one-cycle `rewind` pulse on the next cycle. It clears the frame byte count to zero and does not set `err_flag`.
- R7: A `collision` in STREAM sets `err_flag`, clears `tx_en`, and loads `err_frame_id` with the `frame_id` captured at that frame's start, all on the next cycle.
- R8: While `tx_en` is 0, `frame_start`, `byte_sent`, `collision` and `frame_end` are ignored. No release or rewind occurs, and no frame is started.
- R9: `enable_wr` in HALT sets `tx_en` to 1 and clears `err_flag` on the next cycle. In any other state it has no effect. `err_flag` and `err_frame_id` hold until that write.
- R10: A `collision` overrides `byte_sent` and `frame_end` in the same cycle. A `byte_sent` together with `frame_end` is counted and released before the frame closes.
- R11: `frame_start` is accepted only in IDLE, where it clears the byte count. In HOLD or STREAM it is ignored and the count continues.
- R12: A threshold of 0 releases the first byte of a frame alone, on the cycle after it is sent. The threshold input is evaluated on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thresh_words | input | THR_W (8) | Release threshold in 16-byte units; all ones disables early release |
| frame_start | input | 1 | Start-of-frame strobe |
| frame_id | input | ID_W (4) | Identifier of the frame, sampled with `frame_start` |
| byte_sent | input | 1 | One byte of the frame was sent to the network |
| collision | input | 1 | Collision reported by the MAC |
| frame_end | input | 1 | End-of-frame strobe |
| enable_wr | input | 1 | Software write of the transmit enable bit |
| rel_valid | output | 1 | Release pulse |
| rel_bytes | output | CNT_W (12) | Bytes returned to the FIFO with the pulse |
| rewind | output | 1 | Request to restart the frame read from its start |
| tx_en | output | 1 | Transmitter enable |
| err_flag | output | 1 | Release-error status |
| err_frame_id | output | ID_W (4) | Identifier of the frame that hit the release error |

## Verification
The bench builds the block with its defaults: a 12-bit byte counter, 8-bit threshold and 4-bit frame identifier. With these values the reset threshold of 8 words (128 bytes), the low thresholds 0, 1, 2 and 4, and the 0xFF disable code can all be reached with short frames. A 12-bit count also covers a 0xFE threshold (4064 bytes) without wrap, so the threshold comparison is tested at its real width. Collisions are placed on both sides of the crossing point and together with byte and end strobes, which exercises every transition of the four states.

// File: rtl/txrel_pkg.sv
package txrel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_STREAM = 2'd2,
        ST_HALT   = 2'd3
    } txrel_state_e;

    localparam int unsigned WORD_SHIFT = 4;

endpackage

// File: rtl/txrel_thresh.sv
module txrel_thresh #(
    parameter int unsigned THR_W = 8,
    parameter int unsigned CNT_W = 12
) (
    input  logic [THR_W-1:0] thresh_words,
    output logic [CNT_W-1:0] thr_bytes,
    output logic             early_off
);
    import txrel_pkg::*;

    localparam int unsigned FULL_W = THR_W + WORD_SHIFT;

    logic [FULL_W-1:0] scaled;

    assign scaled    = {thresh_words, {WORD_SHIFT{1'b0}}};
    assign early_off = &thresh_words;

    generate
        if (CNT_W >= FULL_W) begin : g_fit
            assign thr_bytes = CNT_W'(scaled);
        end else begin : g_sat
            logic over;
            assign over      = |scaled[FULL_W-1:CNT_W];
            assign thr_bytes = over ? {CNT_W{1'b1}} : scaled[CNT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/txrel_bytecnt.sv
module txrel_bytecnt #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             byte_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_plus
);

    assign count_plus = count + CNT_W'(byte_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count_plus;
        end
    end

endmodule

// File: rtl/txrel_fsm.sv
module txrel_fsm #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [ID_W-1:0]  frame_id,
    input  logic             byte_sent,
    input  logic             collision,
    input  logic             frame_end,
    input  logic             enable_wr,
    input  logic [CNT_W-1:0] count_plus,
    input  logic [CNT_W-1:0] thr_bytes,
    input  logic             early_off,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             rel_valid,
    output logic [CNT_W-1:0] rel_bytes,
    output logic             rewind,
    output logic             tx_en,
    output logic             err_flag,
    output logic [ID_W-1:0]  err_frame_id
);
    import txrel_pkg::*;

    txrel_state_e state, state_n;

    logic             rel_v_n;
    logic [CNT_W-1:0] rel_b_n;
    logic             rewind_n;
    logic             err_set;
    logic             err_clr;
    logic             id_load;
    logic             crossed;
    logic [ID_W-1:0]  cur_id;

    assign crossed = byte_sent && !early_off && (count_plus >= thr_bytes);

    // next state and per-cycle decisions
    always_comb begin
        state_n  = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        rel_v_n  = 1'b0;
        rel_b_n  = '0;
        rewind_n = 1'b0;
        err_set  = 1'b0;
        err_clr  = 1'b0;
        id_load  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (frame_start) begin
                    state_n = ST_HOLD;
                    cnt_clr = 1'b1;
                    id_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (collision) begin
                    rewind_n = 1'b1;
                    cnt_clr  = 1'b1;
                end else begin
                    cnt_inc = byte_sent;
                    if (frame_end) begin
                        state_n = ST_IDLE;
                        rel_v_n = (count_plus != '0);
                        rel_b_n = (count_plus != '0) ? count_plus : '0;
                    end else if (crossed) begin
                        state_n = ST_STREAM;
                        rel_v_n = 1'b1;
                        rel_b_n = count_plus;
                    end
                end
            end
            ST_STREAM: begin
                if (collision) begin
                    state_n = ST_HALT;
                    err_set = 1'b1;
                end else begin
                    if (byte_sent) begin
                        rel_v_n = 1'b1;
                        rel_b_n = CNT_W'(1);
                    end
                    if (frame_end) begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_HALT: begin
                if (enable_wr) begin
                    state_n = ST_IDLE;
                    err_clr = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // registered outputs and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_valid    <= 1'b0;
            rel_bytes    <= '0;
            rewind       <= 1'b0;
            err_flag     <= 1'b0;
            err_frame_id <= '0;
            cur_id       <= '0;
        end else begin
            rel_valid <= rel_v_n;
            rel_bytes <= rel_b_n;
            rewind    <= rewind_n;
            if (id_load) begin
                cur_id <= frame_id;
            end
            if (err_set) begin
                err_flag     <= 1'b1;
                err_frame_id <= cur_id;
            end else if (err_clr) begin
                err_flag <= 1'b0;
            end
        end
    end

    assign tx_en = (state != ST_HALT);

endmodule

// File: rtl/txrel_ctrl.sv
module txrel_ctrl #(
    parameter int unsigned THR_W = 8,
    parameter int unsigned CNT_W = 12,
    parameter int unsigned ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thresh_words,
    input  logic             frame_start,
    input  logic [ID_W-1:0]  frame_id,
    input  logic             byte_sent,
    input  logic             collision,
    input  logic             frame_end,
    input  logic             enable_wr,
    output logic             rel_valid,
    output logic [CNT_W-1:0] rel_bytes,
    output logic             rewind,
    output logic             tx_en,
    output logic             err_flag,
    output logic [ID_W-1:0]  err_frame_id
);

    logic [CNT_W-1:0] thr_bytes;
    logic             early_off;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_plus;

    txrel_thresh #(.THR_W(THR_W), .CNT_W(CNT_W)) u_thresh (
        .thresh_words (thresh_words),
        .thr_bytes    (thr_bytes),
        .early_off    (early_off)
    );

    txrel_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .inc        (cnt_inc),
        .byte_in    (byte_sent),
        .count      (count),
        .count_plus (count_plus)
    );

    txrel_fsm #(.CNT_W(CNT_W), .ID_W(ID_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .frame_id     (frame_id),
        .byte_sent    (byte_sent),
        .collision    (collision),
        .frame_end    (frame_end),
        .enable_wr    (enable_wr),
        .count_plus   (count_plus),
        .thr_bytes    (thr_bytes),
        .early_off    (early_off),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .rel_valid    (rel_valid),
        .rel_bytes    (rel_bytes),
        .rewind       (rewind),
        .tx_en        (tx_en),
        .err_flag     (err_flag),
        .err_frame_id (err_frame_id)
    );

    logic unused_count;
    assign unused_count = ^count;

endmodule

// File: rtl/txrel_ctrl_chk.sv
module txrel_ctrl_chk #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned ID_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_wr,
    input logic             rel_valid,
    input logic [CNT_W-1:0] rel_bytes,
    input logic             rewind,
    input logic             tx_en,
    input logic             err_flag,
    input logic [ID_W-1:0]  err_frame_id
);

    a_r2_rel_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_bytes != '0));

    a_r1_idle_bytes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_valid |-> (rel_bytes == '0));

    a_r7_err_stops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !tx_en);

    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!rel_valid && !rewind));

    a_r10_rewind_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> !rel_valid);

    a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !enable_wr) |=> err_flag);

    a_r9_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !enable_wr) |=> $stable(err_frame_id));

endmodule

bind txrel_ctrl txrel_ctrl_chk #(.CNT_W(CNT_W), .ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_wr    (enable_wr),
    .rel_valid    (rel_valid),
    .rel_bytes    (rel_bytes),
    .rewind       (rewind),
    .tx_en        (tx_en),
    .err_flag     (err_flag),
    .err_frame_id (err_frame_id)
);

// File: tb/txrel_ctrl_bench.sv
`timescale 1ns/1ps
module txrel_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  thresh_words = 8'h08;
    logic        frame_start = 1'b0;
    logic [3:0]  frame_id = 4'd0;
    logic        byte_sent = 1'b0;
    logic        collision = 1'b0;
    logic        frame_end = 1'b0;
    logic        enable_wr = 1'b0;
    logic        rel_valid;
    logic [11:0] rel_bytes;
    logic        rewind;
    logic        tx_en;
    logic        err_flag;
    logic [3:0]  err_frame_id;

    always #5 clk = ~clk;

    txrel_ctrl u_txrel_ctrl (
        .clk(clk), .rst_n(rst_n), .thresh_words(thresh_words),
        .frame_start(frame_start), .frame_id(frame_id), .byte_sent(byte_sent),
        .collision(collision), .frame_end(frame_end), .enable_wr(enable_wr),
        .rel_valid(rel_valid), .rel_bytes(rel_bytes), .rewind(rewind),
        .tx_en(tx_en), .err_flag(err_flag), .err_frame_id(err_frame_id)
    );

    // reference model state: 0 idle, 1 counting, 2 streaming, 3 halted
    int    m_st = 0;
    int    m_cnt = 0;
    int    m_id = 0;
    int    e_rv = 0;
    int    e_rb = 0;
    int    e_rw = 0;
    int    e_err = 0;
    int    e_eid = 0;
    int    checks = 0;
    int    fails = 0;
    int    rel_total = 0;
    string req = "R1";

    task automatic check(string r, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(req, int'(rel_valid), e_rv, "rel_valid");
        check(req, int'(rel_bytes), e_rb, "rel_bytes");
        check(req, int'(rewind), e_rw, "rewind");
        check(req, int'(tx_en), (m_st == 3) ? 0 : 1, "tx_en");
        check(req, int'(err_flag), e_err, "err_flag");
        check(req, int'(err_frame_id), e_eid, "err_frame_id");
    endtask

    task automatic model_update();
        int thr;
        thr  = int'(thresh_words) * 16;
        e_rv = 0; e_rb = 0; e_rw = 0;
        case (m_st)
            0: if (frame_start) begin m_st = 1; m_cnt = 0; m_id = int'(frame_id); end
            1: begin
                if (collision) begin
                    e_rw = 1; m_cnt = 0;
                end else begin
                    if (byte_sent) m_cnt++;
                    if (frame_end) begin
                        if (m_cnt > 0) begin e_rv = 1; e_rb = m_cnt; end
                        m_st = 0;
                    end else if (byte_sent && thresh_words != 8'hFF && m_cnt >= thr) begin
                        e_rv = 1; e_rb = m_cnt; m_st = 2;
                    end
                end
            end
            2: begin
                if (collision) begin
                    m_st = 3; e_err = 1; e_eid = m_id;
                end else begin
                    if (byte_sent) begin e_rv = 1; e_rb = 1; end
                    if (frame_end) m_st = 0;
                end
            end
            default: if (enable_wr) begin m_st = 0; e_err = 0; end
        endcase
        if (e_rv != 0) rel_total += e_rb;
    endtask

    // one clock: compare, drive, clock, model
    task automatic step(bit s, bit b, bit c, bit e, bit w);
        @(negedge clk);
        compare_all();
        frame_start = s; byte_sent = b; collision = c; frame_end = e; enable_wr = w;
        @(posedge clk);
        #1;
        model_update();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic bytes(int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0);
    endtask

    task automatic start(int id);
        frame_id = id[3:0];
        step(1, 0, 0, 0, 0);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        req = "R1";
        check("R1", int'(tx_en), 1, "tx_en at reset");
        check("R1", int'(err_flag), 0, "err_flag at reset");
        check("R1", int'(rel_valid), 0, "rel_valid at reset");
        rst_n = 1'b1;
        idle(2);

        // R2 R3: reset threshold 0x08 = 128 bytes
        req = "R2"; thresh_words = 8'h08; rel_total = 0;
        start(3); bytes(127); idle(2); bytes(1);
        req = "R3"; bytes(2); step(0, 1, 0, 1, 0); idle(2);
        check("R3", rel_total, 131, "bytes released for 131-byte frame");

        // R4: disable code, frame of 50 bytes
        req = "R4"; thresh_words = 8'hFF; rel_total = 0;
        start(5); bytes(49); step(0, 1, 0, 1, 0); idle(2);
        check("R4", rel_total, 50, "whole frame released at end");

        // R5: frame shorter than threshold, then empty frame
        req = "R5"; thresh_words = 8'h08;
        start(6); bytes(20); step(0, 0, 0, 1, 0); idle(1);
        start(7); step(0, 0, 0, 1, 0); idle(2);

        // R6: collision before crossing rewinds, then retry crosses at 64
        req = "R6"; thresh_words = 8'h04;
        start(8); bytes(30); step(0, 0, 1, 0, 0); idle(1);
        bytes(64); bytes(2); step(0, 0, 0, 1, 0); idle(2);

        // R7: collision after crossing -> release error with id 9
        req = "R7"; thresh_words = 8'h01;
        start(9); bytes(19); step(0, 0, 1, 0, 0); idle(1);
        check("R7", int'(err_frame_id), 9, "error frame id");

        // R8: everything ignored while halted
        req = "R8";
        start(2); bytes(5); step(0, 0, 1, 0, 0); step(0, 1, 0, 1, 0); idle(2);

        // R9: enable write recovers; write while running has no effect
        req = "R9";
        step(0, 0, 0, 0, 1); idle(1);
        step(0, 0, 0, 0, 1); idle(1);
        start(4); step(0, 1, 0, 0, 1); bytes(3); step(0, 0, 0, 1, 0); idle(2);

        // R10: collision beats byte and end in the same cycle
        req = "R10"; thresh_words = 8'h02;
        start(10); bytes(5); step(0, 1, 1, 1, 0); bytes(3); step(0, 1, 0, 1, 0); idle(2);
        start(11); bytes(33); step(0, 1, 1, 1, 0); idle(1);
        step(0, 0, 0, 0, 1); idle(1);

        // R11: start ignored mid-frame; new frame count starts at zero
        req = "R11";
        start(12); bytes(20); step(1, 0, 0, 0, 0); bytes(12); bytes(2); step(0, 0, 0, 1, 0);
        start(13); bytes(31); idle(1); bytes(1); bytes(1); step(0, 0, 0, 1, 0); idle(2);

        // R12: threshold zero, and live change of threshold
        req = "R12"; thresh_words = 8'h00;
        start(14); bytes(3); step(0, 0, 0, 1, 0); idle(1);
        thresh_words = 8'hFE;
        start(15); bytes(10); thresh_words = 8'h00; bytes(1); bytes(1); step(0, 0, 0, 1, 0);
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule